// File: doc/BRIEF.md
# Linear-Sweep Phase Accumulator Core

This block is the numeric heart of a direct digital synthesizer that can sweep its output frequency linearly. A phase accumulator advances every clock by a frequency tuning word. When sweeping is enabled, a second frequency accumulator is added to that tuning word. The frequency accumulator moves by a signed delta word once per ramp interval. The ramp interval is set by a reload value for a down-counter. The output is the top slice of the phase accumulator, optionally shifted a quarter turn so that a downstream amplitude table produces a cosine instead of a sine.

Software-side writes go over a narrow register port into shadow copies of the tuning words. A single-cycle update strobe copies the shadows into the working registers. The ramp interval can instead be made to take effect as soon as it is written. Control bits decide whether a strobe restarts each accumulator from zero, and two clear bits hold an accumulator at zero for as long as they stay set. Control bits take effect on the clock after they are written.

Top module: `sweep_dds_core`

## Requirements
- R1: After reset the output phase word is 0, and all tuning words and control bits are zero.
- R2: Register addresses are: 0 phase-step word, 1 signed sweep-delta word, 2 ramp interval (low 16 bits), and 3 control. Writes to addresses 0 and 1 go to shadow registers and do not affect the output until an update strobe copies them.
- R3: The phase accumulator (32 bits, wraps modulo 2^32) adds the committed phase-step word every clock. The output phase word is accumulator bits 31:18 when the cosine bit is clear.
- R4: Control bit 6 (cosine) adds 0x1000 to the output phase word, wrapping modulo 2^14.
- R5: With control bit 2 set, an update strobe makes the phase accumulator 0 on that clock edge. The accumulator then resumes adding from zero.
- R6: With control bits 1 and 2 clear, an update strobe changes the words in use, and both accumulators continue from their held values.
- R7: While control bit 4 is set, the phase accumulator is held at 0. Accumulation restarts from 0 on the first edge after the bit reads clear.
- R8: With control bit 0 (sweep) set, the frequency accumulator adds the signed delta word on every ramp tick. The phase accumulator adds the frequency accumulator to the phase-step word with two's-complement wraparound.
- R9: With control bit 0 clear, the frequency accumulator holds and contributes nothing to the phase step.
- R10: A ramp interval of N gives one ramp tick every N+1 clocks. An update strobe reloads the interval counter, so the first tick comes N+1 clocks after the strobe.
- R11: With control bit 5 set, a written ramp interval waits for an update strobe. With the bit clear, it is used from the next counter reload after the write.
- R12: While control bit 3 is set, the frequency accumulator is held at 0. With control bit 1 set, an update strobe zeroes it.

Top module port order and widths follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| fud | input | 1 | One-cycle update strobe committing shadow words |
| phase_out | output | 14 | Truncated output phase word |

## Verification
The bench aims at the moments when state restarts. It checks that a strobe with auto-clear set restarts from zero, and that one with auto-clear clear keeps the phase. A design that mixed these up would lose phase continuity or fail to realign the sweep. It also writes a new ramp interval in the middle of a sweep. That write changes the quadratic phase result in immediate mode and leaves it unchanged in strobe mode, so swapping the modes shows up as a wrong phase count. Negative delta words, a cosine offset that wraps past 2^14, and the clear-and-hold bits are all checked. These catch sign-extension mistakes, missing wraparound, and clears that only act for one cycle.

// File: rtl/sdds_pkg.sv
package sdds_pkg;

  typedef struct packed {
    logic cosine;
    logic ramp_on_fud;
    logic clr_phase;
    logic clr_freq;
    logic autoclr_phase;
    logic autoclr_freq;
    logic sweep_en;
  } sdds_ctrl_t;

  localparam int CTRL_W = $bits(sdds_ctrl_t);

  localparam logic [1:0] REG_FTW  = 2'd0;
  localparam logic [1:0] REG_DFTW = 2'd1;
  localparam logic [1:0] REG_RATE = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

endpackage

// File: rtl/sdds_regbank.sv
module sdds_regbank
  import sdds_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              fud,
  output sdds_ctrl_t        ctrl_o,
  output logic [ACC_W-1:0]  ftw_o,
  output logic [ACC_W-1:0]  dftw_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [RATE_W-1:0] rate_load_o
);

  logic [ACC_W-1:0]  sh_ftw_q, sh_ftw_d;
  logic [ACC_W-1:0]  sh_dftw_q, sh_dftw_d;
  logic [RATE_W-1:0] sh_rate_q, sh_rate_d;
  logic [ACC_W-1:0]  ftw_q, ftw_d;
  logic [ACC_W-1:0]  dftw_q, dftw_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  sdds_ctrl_t        ctrl_q, ctrl_d;

  logic wr_ftw, wr_dftw, wr_rate, wr_ctrl;

  always_comb begin
    wr_ftw  = wr_en && (wr_addr == REG_FTW);
    wr_dftw = wr_en && (wr_addr == REG_DFTW);
    wr_rate = wr_en && (wr_addr == REG_RATE);
    wr_ctrl = wr_en && (wr_addr == REG_CTRL);

    sh_ftw_d  = wr_ftw  ? wr_data : sh_ftw_q;
    sh_dftw_d = wr_dftw ? wr_data : sh_dftw_q;
    sh_rate_d = wr_rate ? wr_data[RATE_W-1:0] : sh_rate_q;
    ctrl_d    = wr_ctrl ? sdds_ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;

    ftw_d  = fud ? sh_ftw_q  : ftw_q;
    dftw_d = fud ? sh_dftw_q : dftw_q;

    rate_d = rate_q;
    if (fud) rate_d = sh_rate_q;
    if (wr_rate && !ctrl_q.ramp_on_fud) rate_d = wr_data[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ftw_q  <= '0;
      sh_dftw_q <= '0;
      sh_rate_q <= '0;
      ftw_q     <= '0;
      dftw_q    <= '0;
      rate_q    <= '0;
      ctrl_q    <= '0;
    end else begin
      sh_ftw_q  <= sh_ftw_d;
      sh_dftw_q <= sh_dftw_d;
      sh_rate_q <= sh_rate_d;
      ftw_q     <= ftw_d;
      dftw_q    <= dftw_d;
      rate_q    <= rate_d;
      ctrl_q    <= ctrl_d;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign ftw_o       = ftw_q;
  assign dftw_o      = dftw_q;
  assign rate_o      = rate_q;
  assign rate_load_o = rate_d;

  // R2
  words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fud |=> ($stable(ftw_q) && $stable(dftw_q)));

endmodule

// File: rtl/sdds_ramp_timer.sv
module sdds_ramp_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fud,
  input  logic [RATE_W-1:0] rate,
  input  logic [RATE_W-1:0] rate_load,
  output logic              tick
);

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              expired;

  always_comb begin
    expired = (cnt_q == '0);
    tick    = expired && !fud;
    if (fud)          cnt_d = rate_load;
    else if (expired) cnt_d = rate;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10
  ramp_no_early_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fud && rate_load != '0) |=> !tick);

endmodule

// File: rtl/sdds_freq_acc.sv
module sdds_freq_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fud,
  input  logic             tick,
  input  logic             sweep_en,
  input  logic             autoclr,
  input  logic             clr_hold,
  input  logic [ACC_W-1:0] dftw,
  output logic [ACC_W-1:0] facc
);

  logic [ACC_W-1:0] facc_q, facc_d;

  always_comb begin
    if (clr_hold)                facc_d = '0;
    else if (fud && autoclr)     facc_d = '0;
    else if (tick && sweep_en)   facc_d = facc_q + dftw;
    else                         facc_d = facc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) facc_q <= '0;
    else        facc_q <= facc_d;
  end

  assign facc = facc_q;

  // R12
  freq_clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hold |=> (facc_q == '0));

  // R9
  freq_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sweep_en && !clr_hold && !fud) |=> $stable(facc_q));

endmodule

// File: rtl/sdds_phase_acc.sv
module sdds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fud,
  input  logic             sweep_en,
  input  logic             autoclr,
  input  logic             clr_hold,
  input  logic             cosine,
  input  logic [ACC_W-1:0] ftw,
  input  logic [ACC_W-1:0] facc,
  output logic [OUT_W-1:0] phase_out
);

  localparam logic [OUT_W-1:0] QUARTER = OUT_W'(1) << (OUT_W - 2);

  logic [ACC_W-1:0] pacc_q, pacc_d;
  logic [ACC_W-1:0] step;

  always_comb begin
    step = ftw + (sweep_en ? facc : '0);
    if (clr_hold)            pacc_d = '0;
    else if (fud && autoclr) pacc_d = '0;
    else                     pacc_d = pacc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pacc_q <= '0;
    else        pacc_q <= pacc_d;
  end

  assign phase_out = pacc_q[ACC_W-1 -: OUT_W] + (cosine ? QUARTER : '0);

  // R7
  phase_clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hold |=> (pacc_q == '0));

  // R5
  phase_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fud && autoclr) |=> (pacc_q == '0));

endmodule

// File: rtl/sweep_dds_core.sv
module sweep_dds_core
  import sdds_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 14,
  parameter int RATE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             fud,
  output logic [OUT_W-1:0] phase_out
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  sdds_ctrl_t        ctrl;
  logic [ACC_W-1:0]  ftw, dftw, facc;
  logic [RATE_W-1:0] rate, rate_load;
  logic              tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdds_regbank #(.ACC_W(ACC_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fud(fud), .ctrl_o(ctrl), .ftw_o(ftw),
    .dftw_o(dftw), .rate_o(rate), .rate_load_o(rate_load)
  );

  sdds_ramp_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .fud(fud), .rate(rate),
    .rate_load(rate_load), .tick(tick)
  );

  sdds_freq_acc #(.ACC_W(ACC_W)) u_facc (
    .clk(clk), .rst_n(rst_int_n), .fud(fud), .tick(tick),
    .sweep_en(ctrl.sweep_en), .autoclr(ctrl.autoclr_freq),
    .clr_hold(ctrl.clr_freq), .dftw(dftw), .facc(facc)
  );

  sdds_phase_acc #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_pacc (
    .clk(clk), .rst_n(rst_int_n), .fud(fud), .sweep_en(ctrl.sweep_en),
    .autoclr(ctrl.autoclr_phase), .clr_hold(ctrl.clr_phase),
    .cosine(ctrl.cosine), .ftw(ftw), .facc(facc), .phase_out(phase_out)
  );

endmodule

// File: tb/test_sweep_dds_core.sv
`timescale 1ns/1ps
module test_sweep_dds_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        fud;
  logic [13:0] phase_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sweep_dds_core i_sweep_dds_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fud(fud), .phase_out(phase_out)
  );

  localparam logic [31:0] STEP1 = 32'h0004_0000;

  // table: phase-step word, edges after strobe, cosine bit
  typedef struct packed {
    logic [31:0] ftw;
    logic [7:0]  edges;
    logic        cos;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0004_0000, 8'd5, 1'b0},
    '{32'h0004_0000, 8'd5, 1'b1},
    '{32'h0100_0000, 8'd3, 1'b0},
    '{32'h8000_0000, 8'd3, 1'b0},
    '{32'hFFFC_0000, 8'd4, 1'b1}
  };

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    fud = 1'b1;
    @(negedge clk);
    fud = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [13:0] q;
    logic [31:0] prod;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; fud = 1'b0;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(3);
    // R1: reset state
    chk("R1 reset phase", phase_out, 14'h0);

    // R2: shadow write without strobe leaves output unchanged
    wr(2'd0, STEP1);
    wait_edges(5);
    chk("R2 shadow not committed", phase_out, 14'h0);

    // R3 / R4 / R5: table walk, each run restarted by auto-clear strobe
    foreach (VECS[i]) begin
      wr(2'd3, 32'h4 | (32'(VECS[i].cos) << 6));
      wr(2'd0, VECS[i].ftw);
      strobe();
      wait_edges(int'(VECS[i].edges));
      prod = VECS[i].ftw * 32'(VECS[i].edges);
      chk(VECS[i].cos ? "R4 cosine phase" : "R3 R5 sine phase",
          phase_out, prod[31:18] + (VECS[i].cos ? 14'h1000 : 14'h0));
    end

    // R6: strobe without auto-clear keeps accumulated phase
    wr(2'd3, 32'h4);
    wr(2'd0, STEP1);
    strobe();
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h0008_0000);
    wait_edges(1);
    q = phase_out;
    strobe();
    wait_edges(3);
    chk("R6 continuity", phase_out, q + 14'd8);

    // R7: clear-and-hold of the phase accumulator
    wr(2'd3, 32'h10);
    wait_edges(1);
    chk("R7 phase held at zero", phase_out, 14'h0);
    wait_edges(4);
    chk("R7 phase still zero", phase_out, 14'h0);
    wr(2'd3, 32'h0);
    wait_edges(3);
    chk("R7 resume from zero", phase_out, 14'd6);

    // R8: positive sweep, interval 0
    wr(2'd3, 32'h7);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd1, STEP1);
    strobe();
    wait_edges(6);
    chk("R8 sweep positive", phase_out, 14'd15);

    // R8: negative delta word
    wr(2'd1, 32'hFFFC_0000);
    strobe();
    wait_edges(6);
    chk("R8 sweep negative", phase_out, 14'd16369);

    // R9: sweep bit clear contributes nothing
    wr(2'd3, 32'h6);
    wr(2'd1, STEP1);
    strobe();
    wait_edges(6);
    chk("R9 sweep off", phase_out, 14'h0);

    // R12: frequency clear-and-hold while sweeping
    wr(2'd3, 32'hF);
    strobe();
    wait_edges(6);
    chk("R12 freq held at zero", phase_out, 14'h0);

    // R10 / R11: immediate interval write mid-sweep
    wr(2'd3, 32'h7);
    wr(2'd2, 32'd2);
    strobe();
    wr(2'd2, 32'd0);
    wait_edges(5);
    chk("R11 immediate interval", phase_out, 14'd10);

    // R10 / R11: strobe-gated interval ignores mid-sweep write
    wr(2'd3, 32'h27);
    wr(2'd2, 32'd2);
    strobe();
    wr(2'd2, 32'd0);
    wait_edges(5);
    chk("R10 R11 gated interval", phase_out, 14'd5);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule